// File: doc/BRIEF.md
# Line Loopback and All-Ones Data Selector

This block is the digital data-path selector of a T1/E1 line interface. It sits between the terminal side, which supplies dual-rail transmit data with its transmit clock, and the line side, which supplies dual-rail recovered receive data with the recovered clock. It decides what goes out toward the line and what is presented back to the terminal. The decision depends on three control inputs: remote loopback, local loopback and transmit-all-ones. A fourth input picks the receive-clock edge on which the receive outputs change.

The block runs in a single fast core clock domain. Both line-rate clocks arrive as levels that the core clock oversamples, and each path advances only on the detected edges of its own line clock. The three control inputs are asynchronous and pass through a synchronizer before they can alter the path. Raising both loopback controls at once is not a combined mode. The block reads it as a reset request: it emits a reset pulse, clears the all-ones polarity, and keeps every path on its normal route. The reset input is asynchronous and active-low, and its release is assumed to be synchronous to the core clock upstream.

Top module: `line_loop_sel`

## Requirements
- R1: With remote loopback synchronized high and local loopback low, the line outputs copy the receive inputs (`rx_pos_i`/`rx_neg_i`), updated on each detected rising edge of `rclk_i`, and terminal transmit data is not sent.
- R2: With local loopback synchronized high and remote loopback low, the receive outputs copy the terminal transmit inputs, updated on the `tclk_i` edge chosen by `rx_fall_sel_i`, while the line outputs keep carrying the transmit stream.
- R3: When both loopback controls become high together (after synchronization), `lb_rst_o` goes high on the next core clock and stays high until `RST_TCLKS` (default 4) further rising edges of `tclk_i` have been counted. No loopback is applied while both controls are high.
- R4: With transmit-all-ones effective, each rising edge of `tclk_i` places one mark on the line, alternating between `line_pos_o` and `line_neg_o`, never on both. The values of `tx_pos_i`/`tx_neg_i` have no effect.
- R5: Transmit-all-ones has no effect while remote loopback is active; the line then carries the looped receive data.
- R6: With `rx_fall_sel_i` high, the receive outputs change only on detected falling edges of their source clock. With it low, they change only on detected rising edges.
- R7: Each control input passes through a two-stage synchronizer. A change sampled at one core clock edge alters the path from the second following edge on.
- R8: The all-ones polarity is cleared whenever all-ones is not effective, including the start cycle and the whole duration of a loopback reset pulse. The first mark after all-ones becomes effective is always on `line_pos_o`.
- R9: During reset all outputs are low.
- R10: In the normal path, the line outputs copy the transmit inputs on each rising edge of `tclk_i`, and the receive outputs copy the receive inputs on the selected edge of `rclk_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples both line clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_i | input | 1 | Transmit line clock level |
| rclk_i | input | 1 | Recovered receive clock level |
| tx_pos_i | input | 1 | Terminal transmit data, positive rail |
| tx_neg_i | input | 1 | Terminal transmit data, negative rail |
| rx_pos_i | input | 1 | Recovered receive data, positive rail |
| rx_neg_i | input | 1 | Recovered receive data, negative rail |
| rmt_lb_i | input | 1 | Remote loopback request (asynchronous) |
| loc_lb_i | input | 1 | Local loopback request (asynchronous) |
| all_ones_i | input | 1 | Transmit-all-ones request (asynchronous) |
| rx_fall_sel_i | input | 1 | 1: receive outputs change on falling edges; 0: on rising edges |
| line_pos_o | output | 1 | Data toward the line, positive rail |
| line_neg_o | output | 1 | Data toward the line, negative rail |
| rcv_pos_o | output | 1 | Data toward the terminal, positive rail |
| rcv_neg_o | output | 1 | Data toward the terminal, negative rail |
| lb_rst_o | output | 1 | Reset pulse raised by simultaneous loopback requests |

## Verification
The hardest cases to reach from the ports are the overlaps. A control change can still be in the synchronizer when a line-clock edge arrives. All-ones can be requested during a loopback reset pulse or while remote loopback is on. The two loopbacks can be entered directly from each other. The bench sweeps every combination of the three controls in both edge-select settings, running line clocks of different periods and pseudo-random data on both rails. It also steps through hand-picked sequences such as both-high followed by remote-only, or both-high while all-ones toggles. A cycle model built from the requirements predicts every output on every core clock. The pulse length is counted separately, against the transmit-clock edges seen on the port.

// File: rtl/line_loop_pkg.sv
package line_loop_pkg;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'd0,
    PATH_REMOTE = 2'd1,
    PATH_LOCAL  = 2'd2,
    PATH_RESET  = 2'd3
  } path_mode_e;

  typedef struct packed {
    logic rmt;
    logic loc;
    logic ones;
  } loop_ctrl_t;

endpackage

// File: rtl/line_loop_sync.sv
module line_loop_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = d_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/line_loop_edge.sv
module line_loop_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/line_loop_ctrl.sv
module line_loop_ctrl
  import line_loop_pkg::*;
#(
  parameter int RST_TCLKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  loop_ctrl_t ctrl_i,
  input  logic       t_rise_i,
  output path_mode_e mode_o,
  output logic       ones_en_o,
  output logic       hold_o,
  output logic       pulse_o
);

  localparam int CNT_W = $clog2(RST_TCLKS + 1);

  logic             both;
  logic             both_q;
  logic             start;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign both  = ctrl_i.rmt & ctrl_i.loc;
  assign start = both & ~both_q;

  always_comb begin
    if (both)             mode_o = PATH_RESET;
    else if (ctrl_i.rmt)  mode_o = PATH_REMOTE;
    else if (ctrl_i.loc)  mode_o = PATH_LOCAL;
    else                  mode_o = PATH_NORMAL;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (start)                           cnt_d = CNT_W'(RST_TCLKS);
    else if (t_rise_i && cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      both_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      both_q <= both;
    end
  end

  assign pulse_o   = (cnt_q != '0);
  assign hold_o    = start | pulse_o;
  assign ones_en_o = ctrl_i.ones & (mode_o != PATH_REMOTE) & ~hold_o;

  AST_PULSE_ENDS_ON_TCLK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> $past(t_rise_i)); // R3
  AST_PULSE_FROM_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(mode_o) == PATH_RESET); // R3

endmodule

// File: rtl/line_loop_ami.sv
module line_loop_ami (
  input  logic clk,
  input  logic rst_n,
  input  logic ones_en_i,
  input  logic hold_i,
  input  logic t_rise_i,
  output logic mark_pos_o,
  output logic mark_neg_o
);

  logic pol_q;
  logic pol_d;

  always_comb begin
    pol_d = pol_q;
    if (!ones_en_i)    pol_d = 1'b0;
    else if (t_rise_i) pol_d = ~pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_d;
  end

  assign mark_pos_o = ~pol_q;
  assign mark_neg_o = pol_q;

  AST_POL_CLEARED_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> !pol_q); // R8

endmodule

// File: rtl/line_loop_sel.sv
module line_loop_sel
  import line_loop_pkg::*;
#(
  parameter int RST_TCLKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tclk_i,
  input  logic rclk_i,
  input  logic tx_pos_i,
  input  logic tx_neg_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic rmt_lb_i,
  input  logic loc_lb_i,
  input  logic all_ones_i,
  input  logic rx_fall_sel_i,
  output logic line_pos_o,
  output logic line_neg_o,
  output logic rcv_pos_o,
  output logic rcv_neg_o,
  output logic lb_rst_o
);

  localparam int CTRL_W = $bits(loop_ctrl_t);

  loop_ctrl_t raw_ctrl;
  loop_ctrl_t sync_ctrl;
  path_mode_e mode;
  logic       ones_en, hold, pulse;
  logic       t_rise, t_fall, r_rise, r_fall;
  logic       mark_pos, mark_neg;
  logic       line_en, rcv_en;
  logic [1:0] line_d, line_q, rcv_d, rcv_q;

  assign raw_ctrl = {rmt_lb_i, loc_lb_i, all_ones_i};

  line_loop_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_ctrl),
    .q_o   (sync_ctrl)
  );

  line_loop_edge u_tedge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (tclk_i),
    .rise_o (t_rise),
    .fall_o (t_fall)
  );

  line_loop_edge u_redge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (rclk_i),
    .rise_o (r_rise),
    .fall_o (r_fall)
  );

  line_loop_ctrl #(.RST_TCLKS(RST_TCLKS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (sync_ctrl),
    .t_rise_i  (t_rise),
    .mode_o    (mode),
    .ones_en_o (ones_en),
    .hold_o    (hold),
    .pulse_o   (pulse)
  );

  line_loop_ami u_ami (
    .clk        (clk),
    .rst_n      (rst_n),
    .ones_en_i  (ones_en),
    .hold_i     (hold),
    .t_rise_i   (t_rise),
    .mark_pos_o (mark_pos),
    .mark_neg_o (mark_neg)
  );

  // Line side: remote loopback retimes on the recovered clock
  always_comb begin
    line_en = (mode == PATH_REMOTE) ? r_rise : t_rise;
    if (mode == PATH_REMOTE) line_d = {rx_pos_i, rx_neg_i};
    else if (ones_en)        line_d = {mark_pos, mark_neg};
    else                     line_d = {tx_pos_i, tx_neg_i};
  end

  // Terminal side: local loopback takes the transmit stream and clock
  always_comb begin
    if (mode == PATH_LOCAL) begin
      rcv_en = rx_fall_sel_i ? t_fall : t_rise;
      rcv_d  = {tx_pos_i, tx_neg_i};
    end else begin
      rcv_en = rx_fall_sel_i ? r_fall : r_rise;
      rcv_d  = {rx_pos_i, rx_neg_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 2'b00;
      rcv_q  <= 2'b00;
    end else begin
      if (line_en) line_q <= line_d;
      if (rcv_en)  rcv_q  <= rcv_d;
    end
  end

  assign line_pos_o = line_q[1];
  assign line_neg_o = line_q[0];
  assign rcv_pos_o  = rcv_q[1];
  assign rcv_neg_o  = rcv_q[0];
  assign lb_rst_o   = pulse;

  AST_REMOTE_LOOPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && mode == PATH_REMOTE) |=> (line_pos_o == $past(rx_pos_i) && line_neg_o == $past(rx_neg_i))); // R1
  AST_LOCAL_LOOPS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_en && mode == PATH_LOCAL) |=> (rcv_pos_o == $past(tx_pos_i) && rcv_neg_o == $past(tx_neg_i))); // R2
  AST_AMI_ONE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (line_en && ones_en) |=> (line_pos_o != line_neg_o)); // R4
  AST_ONES_BLOCKED_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PATH_REMOTE) |-> !ones_en); // R5
  AST_RCV_HELD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !rcv_en |=> $stable({rcv_pos_o, rcv_neg_o})); // R6

endmodule

// File: tb/line_loop_sel_bench.sv
module line_loop_sel_bench;

  localparam int RST_TCLKS = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic tclk_i, rclk_i, tx_pos_i, tx_neg_i, rx_pos_i, rx_neg_i;
  logic rmt_lb_i, loc_lb_i, all_ones_i, rx_fall_sel_i;
  logic line_pos_o, line_neg_o, rcv_pos_o, rcv_neg_o, lb_rst_o;

  always #4 clk = ~clk;  // 125 MHz

  line_loop_sel #(.RST_TCLKS(RST_TCLKS), .SYNC_STAGES(2)) u_line_loop_sel (
    .clk(clk), .rst_n(rst_n), .tclk_i(tclk_i), .rclk_i(rclk_i),
    .tx_pos_i(tx_pos_i), .tx_neg_i(tx_neg_i), .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i),
    .rmt_lb_i(rmt_lb_i), .loc_lb_i(loc_lb_i), .all_ones_i(all_ones_i),
    .rx_fall_sel_i(rx_fall_sel_i),
    .line_pos_o(line_pos_o), .line_neg_o(line_neg_o),
    .rcv_pos_o(rcv_pos_o), .rcv_neg_o(rcv_neg_o), .lb_rst_o(lb_rst_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // ---------------- cycle model built from the requirements ----------------
  logic [2:0] ms1, ms2;       // {remote, local, ones}; two stages (R7)
  logic       mtq, mrq, mbq, mpol;
  int         mcnt;
  logic [1:0] mline, mrcv;

  always @(posedge clk or negedge rst_n) begin
    logic rr, ll, oo, rem, loc, both, trise, tfall, rrise, rfall, start, hold, ones, len, ren;
    if (!rst_n) begin
      ms1 <= '0; ms2 <= '0; mtq <= 0; mrq <= 0; mbq <= 0; mpol <= 0;
      mcnt <= 0; mline <= '0; mrcv <= '0;
    end else begin
      rr = ms2[2]; ll = ms2[1]; oo = ms2[0];
      rem = rr && !ll; loc = ll && !rr; both = rr && ll;
      trise = tclk_i && !mtq; tfall = !tclk_i && mtq;
      rrise = rclk_i && !mrq; rfall = !rclk_i && mrq;
      start = both && !mbq;
      hold  = start || (mcnt != 0);
      ones  = oo && !rem && !hold;
      len   = rem ? rrise : trise;
      if (len) begin
        if (rem)       mline <= {rx_pos_i, rx_neg_i};
        else if (ones) mline <= {!mpol, mpol};
        else           mline <= {tx_pos_i, tx_neg_i};
      end
      if (!ones)      mpol <= 1'b0;
      else if (trise) mpol <= !mpol;
      if (start)                  mcnt <= RST_TCLKS;
      else if (trise && mcnt > 0) mcnt <= mcnt - 1;
      if (loc) begin
        ren = rx_fall_sel_i ? tfall : trise;
        if (ren) mrcv <= {tx_pos_i, tx_neg_i};
      end else begin
        ren = rx_fall_sel_i ? rfall : rrise;
        if (ren) mrcv <= {rx_pos_i, rx_neg_i};
      end
      ms1 <= {rmt_lb_i, loc_lb_i, all_ones_i};
      ms2 <= ms1;
      mtq <= tclk_i; mrq <= rclk_i; mbq <= both;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- per-cycle comparison at the falling edge ----------------
  int   rise_cnt = 0;
  logic tclk_last = 1'b0;
  logic pulse_last = 1'b0;
  bit   cmp_en = 1'b0;

  always @(negedge clk) begin
    string tl, tr;
    logic rem, loc;
    if (cmp_en) begin
      rem = ms2[2] && !ms2[1];
      loc = ms2[1] && !ms2[2];
      if ({rmt_lb_i, loc_lb_i, all_ones_i} != ms2 || ms1 != ms2) tl = "R7";
      else if (mcnt != 0)                     tl = "R3";
      else if (rem)                           tl = ms2[0] ? "R5" : "R1";
      else if (ms2[0])                        tl = (mpol == 1'b0) ? "R8" : "R4";
      else                                    tl = "R10";
      tr = loc ? "R2" : (rx_fall_sel_i ? "R6" : "R10");
      check(tl, "line rails", {line_pos_o, line_neg_o}, mline);
      check(tr, "receive rails", {rcv_pos_o, rcv_neg_o}, mrcv);
      check("R3", "lb_rst_o", lb_rst_o, (mcnt != 0));
      if (ms2[0] && !rem && line_pos_o && line_neg_o)
        check("R4", "both rails marked", 1, 0);
      // independent pulse length count against port-level tclk rises
      if (pulse_last && !lb_rst_o) begin
        check("R3", "tclk rises during pulse", rise_cnt, RST_TCLKS);
        rise_cnt = 0;
      end
      if (lb_rst_o && tclk_i && !tclk_last) rise_cnt++;
      pulse_last = lb_rst_o;
    end
    tclk_last = tclk_i;
  end

  // ---------------- stimulus ----------------
  logic [15:0] lfsr = 16'hACE1;
  int tph = 2, rph = 3, tctr = 0, rctr = 0;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tctr++; if (tctr >= tph) begin tctr = 0; tclk_i = !tclk_i; end
      rctr++; if (rctr >= rph) begin rctr = 0; rclk_i = !rclk_i; end
      tx_pos_i = lfsr[0]; tx_neg_i = lfsr[3] & !lfsr[0];
      rx_pos_i = lfsr[7]; rx_neg_i = lfsr[9];
    end
  endtask

  task automatic set_ctrl(input int code);
    rmt_lb_i = code[2]; loc_lb_i = code[1]; all_ones_i = code[0];
  endtask

  initial begin
    int extra [6] = '{7, 4, 6, 3, 7, 1};
    rst_n = 1'b0;
    tclk_i = 0; rclk_i = 0; tx_pos_i = 0; tx_neg_i = 0; rx_pos_i = 0; rx_neg_i = 0;
    rmt_lb_i = 0; loc_lb_i = 0; all_ones_i = 0; rx_fall_sel_i = 0;
    repeat (3) @(posedge clk);
    #2 tx_pos_i = 1; rx_pos_i = 1; tclk_i = 1; rclk_i = 1;
    @(negedge clk);
    check("R9", "line rails in reset", {line_pos_o, line_neg_o}, 0);
    check("R9", "receive rails in reset", {rcv_pos_o, rcv_neg_o}, 0);
    check("R9", "lb_rst_o in reset", lb_rst_o, 0);
    @(posedge clk);
    #2 rst_n = 1'b1; tclk_i = 0; rclk_i = 0;
    cmp_en = 1'b1;
    for (int sel = 0; sel < 2; sel++) begin
      rx_fall_sel_i = sel[0];
      tph = sel ? 3 : 2; rph = sel ? 2 : 3;
      for (int code = 0; code < 8; code++) begin
        set_ctrl(code);
        step(120);
      end
    end
    tph = 4; rph = 3;
    foreach (extra[k]) begin
      set_ctrl(extra[k]);
      step(90);
      if (extra[k] == 7) begin
        all_ones_i = 1'b0; step(40);
        all_ones_i = 1'b1; step(40);
      end
    end
    set_ctrl(0);
    step(60);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule